// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a parallel RGB panel. From a fast source clock it derives a pixel-rate advance strobe with an integer divider. It then steps a horizontal pixel counter and a vertical line counter through the programmed raster. From those two counters it decodes horizontal sync, vertical sync and a data-enable window. It also gives two single-cycle interrupt strobes: one marks the start of each vertical sync, and one marks the start of a chosen active line.

Every timing quantity arrives on its own input, coded as the real count minus one. Each line runs in this order: sync pulse, back porch, active pixels, front porch. Each frame runs through the same four phases, counted in lines. The timing fields are captured into shadow copies while the block is idle and again at each frame boundary, so software can rewrite them at any time without tearing the frame in flight. The divider ratio is the one exception: it is used live.

Top module: `video_timing_gen`

## Requirements
- R1: While `enable` is low, and after reset, `hSync`, `vSync`, `dataEn`, `frameIrq` and `lineIrq` are all low, and `pixelX` and `lineY` are zero.
- R2: With `enable` high, the counters advance once every N source cycles, where N = `clkDivM1`+1, capped at 255 (so a field of 255 gives N = 255). The first advance is on the N-th enabled cycle.
- R3: A line lasts (hSyncW+1)+(hBack+1)+(hActive+1)+(hFront+1) pixel positions. `hSync` is high (active-high) for positions 0 through hSyncW.
- R4: A frame lasts (vSyncW+1)+(vBack+1)+(vActive+1)+(vFront+1) lines. `vSync` is high (active-high) for lines 0 through vSyncW.
- R5: `dataEn` is high exactly when the pixel position lies in [hSyncW+hBack+2, hSyncW+hBack+2+hActive] and the line lies in [vSyncW+vBack+2, vSyncW+vBack+2+vActive].
- R6: `frameIrq` is a one-cycle pulse. It is high in the first source cycle of every vertical sync that follows a completed frame.
- R7: `lineIrq` is a one-cycle pulse. It is high in the first source cycle of the line numbered vSyncW+vBack+2+`lineThresh`, which means the threshold counts active lines from zero.
- R8: Timing fields and `lineThresh` are sampled while `enable` is low and at each frame wrap. A change made mid-frame first takes effect in the following frame.
- R9: `pixelX` and `lineY` report the raw position within the line and the frame, counting from 0 at the first sync position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low holds counters cleared |
| clkDivM1 | input | DIV_W | Pixel divide ratio minus one |
| hSyncW | input | CNT_W | Horizontal sync width minus one |
| hBack | input | CNT_W | Horizontal back porch minus one |
| hActive | input | CNT_W | Active width minus one |
| hFront | input | CNT_W | Horizontal front porch minus one |
| vSyncW | input | CNT_W | Vertical sync width minus one |
| vBack | input | CNT_W | Vertical back porch minus one |
| vActive | input | CNT_W | Active height minus one |
| vFront | input | CNT_W | Vertical front porch minus one |
| lineThresh | input | CNT_W | Active line index for `lineIrq` |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| dataEn | output | 1 | Active video window |
| frameIrq | output | 1 | Start-of-vsync strobe |
| lineIrq | output | 1 | Threshold line strobe |
| pixelX | output | CNT_W+2 | Position within line |
| lineY | output | CNT_W+2 | Line within frame |

## Verification
Some behaviours are checked by assertions on every cycle. The counters hold still between advance strobes. The horizontal counter never passes the line length. `dataEn` never overlaps either sync. The frame strobe lasts one cycle and lands only at the raster origin during vsync. The idle state quiets every output. Other behaviours can only be shown by the bench scenarios, which compare every output against an independent raster model: the exact cycle of each advance under several divide ratios including the saturated one, the porch lengths, the threshold line, and a mid-frame rewrite that must not disturb the frame in flight.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic tick;   // advance counters by one pixel
    logic clear;  // hold counters cleared, capture shadows
  } vtgStrobe_t;
endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] clkDivM1,
  output vtgStrobe_t       strobe
);
  localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] ratioM1;
  logic             lastPhase;

  // Saturate the ratio at its all-ones value.
  always_comb ratioM1 = (clkDivM1 == DIV_MAX) ? clkDivM1 - 1'b1 : clkDivM1;
  always_comb lastPhase = (divCnt >= ratioM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   divCnt <= '0;
    else if (!enable || lastPhase) divCnt <= '0;
    else                         divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strobe.tick  = enable && lastPhase;
    strobe.clear = !enable;
  end
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TOT_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  vtgStrobe_t       strobe,
  input  logic [CNT_W-1:0] hSyncW,
  input  logic [CNT_W-1:0] hBack,
  input  logic [CNT_W-1:0] hActive,
  input  logic [CNT_W-1:0] hFront,
  input  logic [CNT_W-1:0] vSyncW,
  input  logic [CNT_W-1:0] vBack,
  input  logic [CNT_W-1:0] vActive,
  input  logic [CNT_W-1:0] vFront,
  input  logic [CNT_W-1:0] lineThresh,
  output logic             hSync,
  output logic             vSync,
  output logic             dataEn,
  output logic             frameIrq,
  output logic             lineIrq,
  output logic [TOT_W-1:0] pixelX,
  output logic [TOT_W-1:0] lineY
);
  logic [CNT_W-1:0] sHs, sHb, sHa, sHf, sVs, sVb, sVa, sVf, sThr;
  logic [TOT_W-1:0] hCnt, vCnt, nextV;
  logic [TOT_W-1:0] hTotM1, vTotM1, hActLo, hActHi, vActLo, vActHi, vThrLine;
  logic             hEnd, vEnd, loadNow, runQ, hIn, vIn;

  always_comb begin
    hActLo   = TOT_W'(sHs) + TOT_W'(sHb) + TOT_W'(2);
    hActHi   = hActLo + TOT_W'(sHa);
    hTotM1   = hActHi + TOT_W'(sHf) + TOT_W'(1);
    vActLo   = TOT_W'(sVs) + TOT_W'(sVb) + TOT_W'(2);
    vActHi   = vActLo + TOT_W'(sVa);
    vTotM1   = vActHi + TOT_W'(sVf) + TOT_W'(1);
    vThrLine = vActLo + TOT_W'(sThr);
    hEnd     = (hCnt == hTotM1);
    vEnd     = (vCnt == vTotM1);
    nextV    = vEnd ? '0 : vCnt + 1'b1;
    loadNow  = strobe.clear || (strobe.tick && hEnd && vEnd);
  end

  // Shadow copies: captured while idle and at the frame wrap.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sHs, sHb, sHa, sHf, sVs, sVb, sVa, sVf, sThr} <= '0;
    end else if (loadNow) begin
      {sHs, sHb, sHa, sHf} <= {hSyncW, hBack, hActive, hFront};
      {sVs, sVb, sVa, sVf} <= {vSyncW, vBack, vActive, vFront};
      sThr <= lineThresh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0; vCnt <= '0; runQ <= 1'b0;
      frameIrq <= 1'b0; lineIrq <= 1'b0;
    end else begin
      runQ     <= !strobe.clear;
      frameIrq <= 1'b0;
      lineIrq  <= 1'b0;
      if (strobe.clear) begin
        hCnt <= '0;
        vCnt <= '0;
      end else if (strobe.tick) begin
        if (hEnd) begin
          hCnt     <= '0;
          vCnt     <= nextV;
          lineIrq  <= (nextV == vThrLine);
          frameIrq <= vEnd;
        end else begin
          hCnt <= hCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    hIn    = (hCnt >= hActLo) && (hCnt <= hActHi);
    vIn    = (vCnt >= vActLo) && (vCnt <= vActHi);
    hSync  = runQ && (hCnt <= TOT_W'(sHs));
    vSync  = runQ && (vCnt <= TOT_W'(sVs));
    dataEn = runQ && hIn && vIn;
    pixelX = hCnt;
    lineY  = vCnt;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (!hSync && !vSync && !dataEn && hCnt == '0 && vCnt == '0)); // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.tick) |=> ($stable(hCnt) && $stable(vCnt))); // R2
  AST_H_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    hCnt <= hTotM1); // R3
  AST_DE_NO_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> (!hSync && !vSync)); // R5
  AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |-> (hCnt == '0 && vCnt == '0 && vSync)); // R6
  AST_FRAME_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |=> !frameIrq); // R6
  AST_LINE_START: assert property (@(posedge clk) disable iff (!rstN)
    lineIrq |-> (hCnt == '0)); // R7
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [DIV_W-1:0]   clkDivM1,
  input  logic [CNT_W-1:0]   hSyncW,
  input  logic [CNT_W-1:0]   hBack,
  input  logic [CNT_W-1:0]   hActive,
  input  logic [CNT_W-1:0]   hFront,
  input  logic [CNT_W-1:0]   vSyncW,
  input  logic [CNT_W-1:0]   vBack,
  input  logic [CNT_W-1:0]   vActive,
  input  logic [CNT_W-1:0]   vFront,
  input  logic [CNT_W-1:0]   lineThresh,
  output logic               hSync,
  output logic               vSync,
  output logic               dataEn,
  output logic               frameIrq,
  output logic               lineIrq,
  output logic [CNT_W+1:0]   pixelX,
  output logic [CNT_W+1:0]   lineY
);
  localparam int TOT_W = CNT_W + 2;

  vtgStrobe_t strobe;

  vtg_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable),
    .clkDivM1(clkDivM1), .strobe(strobe)
  );

  vtg_datapath #(.CNT_W(CNT_W), .TOT_W(TOT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hSyncW(hSyncW), .hBack(hBack), .hActive(hActive), .hFront(hFront),
    .vSyncW(vSyncW), .vBack(vBack), .vActive(vActive), .vFront(vFront),
    .lineThresh(lineThresh),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn),
    .frameIrq(frameIrq), .lineIrq(lineIrq),
    .pixelX(pixelX), .lineY(lineY)
  );
endmodule

// File: tb/video_timing_gen_tb_top.sv
module video_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int DIV_W = 8;
  localparam int TOT_W = CNT_W + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [DIV_W-1:0] clkDivM1 = '0;
  logic [CNT_W-1:0] hSyncW = '0, hBack = '0, hActive = '0, hFront = '0;
  logic [CNT_W-1:0] vSyncW = '0, vBack = '0, vActive = '0, vFront = '0, lineThresh = '0;
  logic hSync, vSync, dataEn, frameIrq, lineIrq;
  logic [TOT_W-1:0] pixelX, lineY;

  always #(CLK_PERIOD/2) clk = ~clk;

  video_timing_gen #(.CNT_W(CNT_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .clkDivM1(clkDivM1),
    .hSyncW(hSyncW), .hBack(hBack), .hActive(hActive), .hFront(hFront),
    .vSyncW(vSyncW), .vBack(vBack), .vActive(vActive), .vFront(vFront),
    .lineThresh(lineThresh),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn),
    .frameIrq(frameIrq), .lineIrq(lineIrq), .pixelX(pixelX), .lineY(lineY)
  );

  typedef struct { int hs, hb, ha, hf, vs, vb, va, vf, thr; } cfg_t;
  typedef struct { bit hs, vs, de, fi, li; int h, v; string tag; } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int fails = 0;

  task automatic chk(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic applyCfg(cfg_t c);
    hSyncW = CNT_W'(c.hs); hBack = CNT_W'(c.hb); hActive = CNT_W'(c.ha); hFront = CNT_W'(c.hf);
    vSyncW = CNT_W'(c.vs); vBack = CNT_W'(c.vb); vActive = CNT_W'(c.va); vFront = CNT_W'(c.vf);
    lineThresh = CNT_W'(c.thr);
  endtask

  // Driver side of the scoreboard: expected idle samples (R1).
  task automatic pushIdle(int n);
    @(posedge clk); #1;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e = '{hs:0, vs:0, de:0, fi:0, li:0, h:0, v:0, tag:"R1"};
      expQ.push_back(e);
    end
    wait (expQ.size() == 0);
  endtask

  // Raster model built from the requirements, one item per source cycle.
  task automatic pushRun(cfg_t c0, cfg_t c1, int divField, int n, string tag);
    int ratio, h, v, hTot, vTot, hLo, vLo;
    bit tick, fi, li;
    cfg_t cur;
    ratio = (divField == 255) ? 255 : divField + 1;   // R2 saturation
    cur = c0; h = 0; v = 0;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      tick = ((k + 1) % ratio) == 0;
      fi = 0; li = 0;
      if (tick) begin
        hTot = cur.hs + cur.hb + cur.ha + cur.hf + 4;
        vTot = cur.vs + cur.vb + cur.va + cur.vf + 4;
        h++;
        if (h == hTot) begin
          h = 0; v++;
          if (v == vTot) begin
            v = 0; fi = 1; cur = c1;            // R8 new values at wrap
          end
          li = (v == cur.vs + cur.vb + 2 + cur.thr);
        end
      end
      hLo = cur.hs + cur.hb + 2;
      vLo = cur.vs + cur.vb + 2;
      e.hs = (h <= cur.hs);
      e.vs = (v <= cur.vs);
      e.de = (h >= hLo) && (h <= hLo + cur.ha) && (v >= vLo) && (v <= vLo + cur.va);
      e.fi = fi; e.li = li; e.h = h; e.v = v; e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic runScenario(cfg_t c0, cfg_t c1, int divField, int n, int changeAt, string tag);
    @(negedge clk);
    applyCfg(c0);
    clkDivM1 = DIV_W'(divField);
    @(negedge clk);
    enable = 1'b1;
    @(posedge clk); #1;
    pushRun(c0, c1, divField, n, tag);
    if (changeAt > 0) begin
      repeat (changeAt) @(negedge clk);
      applyCfg(c1);
    end
    wait (expQ.size() == 0);
    @(negedge clk);
    enable = 1'b0;
    pushIdle(4);
  endtask

  // Monitor side of the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        chk({e.tag, "/R3"}, "hSync", int'(hSync), int'(e.hs));
        chk({e.tag, "/R4"}, "vSync", int'(vSync), int'(e.vs));
        chk({e.tag, "/R5"}, "dataEn", int'(dataEn), int'(e.de));
        chk({e.tag, "/R6"}, "frameIrq", int'(frameIrq), int'(e.fi));
        chk({e.tag, "/R7"}, "lineIrq", int'(lineIrq), int'(e.li));
        chk({e.tag, "/R9"}, "pixelX", int'(pixelX), e.h);
        chk({e.tag, "/R9"}, "lineY", int'(lineY), e.v);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cfg_t cfgA, cfgB;
    cfgA = '{hs:1, hb:1, ha:3, hf:0, vs:0, vb:0, va:2, vf:0, thr:1};
    cfgB = '{hs:0, hb:0, ha:1, hf:2, vs:1, vb:1, va:1, vf:1, thr:0};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pushIdle(3);                                  // R1 reset state
    runScenario(cfgA, cfgA, 1, 260, 0, "R2");     // ratio 2, 2+ frames
    runScenario(cfgB, cfgB, 0, 130, 0, "R2");     // ratio 1, other porches
    runScenario(cfgA, cfgB, 2, 500, 20, "R8");    // mid-frame rewrite, ratio 3
    runScenario(cfgA, cfgA, 255, 600, 0, "R2");   // saturated divider: 255
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule